// File: doc/BRIEF.md
# Spread-Spectrum Modulation Profile Generator

This block produces, for each of two channels, a signed frequency-offset word that moves along a symmetric triangle in time. The word is meant to be added to the nominal divide ratio of a fractional-N synthesizer. Sweeping the divide ratio this way spreads the output clock's energy over a band and lowers its peak emission. The block runs on the reference clock. It has no analog parts, and it contains neither the fractional accumulator nor the noise-shaping stage that consumes the offset.

Each channel has its own settings: a sweep style (center or down), a 5-bit depth code, a 2-bit rate code and an enable. A single global spread input gates both channels. A channel samples its settings only at its profile wrap point, which is where the offset crosses zero. A one-cycle strobe marks that point. Because of this, turning spreading off lets the current sweep finish at zero instead of stepping the offset.

Top module: `ss_profile_gen`

## Requirements
- R1: While `rstN` is low every offset is zero and every wrap strobe is low. The first clock edge after reset is released is a wrap point, so the strobe is high in the cycle that follows it.
- R2: Down sweep (`chanMode`=0). With depth code c, the offset falls linearly from 0 to −2·c·UNIT offset LSBs over H cycles, then rises linearly back to 0 over the next H cycles. The offset is never positive. In the cycle the wrap strobe is high, the offset is 0.
- R3: Center sweep (`chanMode`=1). The offset rises from 0 to +c·UNIT after H/2 cycles, falls to −c·UNIT at 3H/2 cycles, and returns to 0 at 2H cycles. Its magnitude never exceeds c·UNIT.
- R4: One sweep lasts 2H reference cycles, with H = 2^(HALF_LOG2 + rate). Rate code 0 gives the fastest sweep. A rate code above 2 acts as 2. The wrap strobe is high for exactly one cycle per sweep.
- R5: A depth code of 0 acts as 1, and a code above 20 acts as 20. One code step equals 0.125% peak deviation in center sweep and 0.25% total deviation in down sweep (UNIT offset LSBs per step).
- R6: A channel sweeps only if both its enable and `spreadOn` are high when sampled at its wrap point. Otherwise its offset stays 0 for the whole sweep.
- R7: If a channel's enable drops in the middle of a sweep, that sweep completes unchanged. The offset then stays at 0 from the next wrap point on.
- R8: Changes to sweep style, depth or rate in the middle of a sweep have no effect until the next wrap point.
- R9: The two channels run independently, each with its own style, depth, rate and wrap timing.
- R10: The exported offset is the signed upper 16 bits of a 24-bit accumulator. It never changes by more than one maximum step per cycle, including at a wrap or when spreading is turned off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Asynchronous reset, active low |
| spreadOn | input | 1 | Global spread enable shared by both channels |
| chanEn | input | NCH | Per-channel enable |
| chanMode | input | NCH | Sweep style per channel: 0 down, 1 center |
| chanMag | input | NCH×MAG_W | Depth code per channel |
| chanRate | input | NCH×RATE_W | Rate code per channel |
| offsetOut | output | NCH×OFF_W | Signed frequency-offset word per channel |
| wrapStb | output | NCH | One-cycle pulse at each channel's wrap point |

## Verification
The table-driven part compares the whole offset trace of a sweep, sample by sample, for down and center sweeps at every rate and at several depths. Down and center traces at the same depth separate errors in the offset range from errors in the slope. Each rate code is exercised, which exposes a wrong period length, and depth codes 0 and 31 expose missing saturation. Directed runs change settings and drop enables in the middle of a sweep, clear the global input while both channel enables are high, and run the two channels with different rates at the same time. These show whether latching happens only at the wrap point and whether the channels are kept apart.

// File: rtl/ssmod_pkg.sv
package ssmod_pkg;

  typedef enum logic {
    MODE_DOWN   = 1'b0,
    MODE_CENTER = 1'b1
  } spreadMode_e;

  // strobes from the sweep sequencer to the accumulator datapath (at most one set)
  typedef struct packed {
    logic clear;
    logic snapHi;
    logic snapLo;
    logic stepUp;
    logic stepDn;
  } ctrlStb_t;

endpackage

// File: rtl/ssmod_ctrl.sv
module ssmod_ctrl
  import ssmod_pkg::*;
#(
  parameter int MAG_W     = 5,
  parameter int RATE_W    = 2,
  parameter int MAG_MIN   = 1,
  parameter int MAG_MAX   = 20,
  parameter int RATE_MAX  = 2,
  parameter int HALF_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  spreadMode_e       modeIn,
  input  logic [MAG_W-1:0]  magIn,
  input  logic [RATE_W-1:0] rateIn,
  input  logic              enIn,
  output spreadMode_e       cfgMode,
  output logic [MAG_W-1:0]  cfgCode,
  output logic [RATE_W-1:0] cfgRate,
  output ctrlStb_t          stb,
  output logic              wrapStb
);

  localparam int CNT_W = HALF_LOG2 + RATE_MAX + 2;
  localparam logic [CNT_W-1:0] RESET_CNT = CNT_W'((2 ** (HALF_LOG2 + 1)) - 1);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  halfLen;
  logic [CNT_W-1:0]  quarterLen;
  logic [CNT_W-1:0]  lastCnt;
  logic [CNT_W-1:0]  nextCnt;
  logic              cfgActive;
  logic              isLast;
  logic [MAG_W-1:0]  magSat;
  logic [RATE_W-1:0] rateSat;

  // saturate the requested settings before they are latched
  always_comb begin
    if (magIn < MAG_W'(MAG_MIN))      magSat = MAG_W'(MAG_MIN);
    else if (magIn > MAG_W'(MAG_MAX)) magSat = MAG_W'(MAG_MAX);
    else                              magSat = magIn;
    if (rateIn > RATE_W'(RATE_MAX))   rateSat = RATE_W'(RATE_MAX);
    else                              rateSat = rateIn;
  end

  // sweep geometry from the latched rate
  always_comb begin
    halfLen    = CNT_W'(1) << (HALF_LOG2 + int'(cfgRate));
    quarterLen = halfLen >> 1;
    lastCnt    = (halfLen << 1) - CNT_W'(1);
    nextCnt    = cnt + CNT_W'(1);
    isLast     = (cnt == lastCnt);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt       <= RESET_CNT;
      cfgMode   <= MODE_DOWN;
      cfgCode   <= MAG_W'(MAG_MIN);
      cfgRate   <= '0;
      cfgActive <= 1'b0;
      wrapStb   <= 1'b0;
    end else begin
      wrapStb <= isLast;
      if (isLast) begin
        cnt       <= '0;
        cfgMode   <= modeIn;
        cfgCode   <= magSat;
        cfgRate   <= rateSat;
        cfgActive <= enIn;
      end else begin
        cnt <= nextCnt;
      end
    end
  end

  // segment sequencing: the last cycle of each segment snaps to its exact endpoint
  always_comb begin
    stb = '0;
    if (!cfgActive || isLast) begin
      stb.clear = 1'b1;
    end else if (cfgMode == MODE_DOWN) begin
      if (nextCnt == halfLen)  stb.snapLo = 1'b1;
      else if (cnt < halfLen)  stb.stepDn = 1'b1;
      else                     stb.stepUp = 1'b1;
    end else begin
      if (nextCnt == quarterLen)                 stb.snapHi = 1'b1;
      else if (nextCnt == halfLen + quarterLen)  stb.snapLo = 1'b1;
      else if (cnt < quarterLen)                 stb.stepUp = 1'b1;
      else if (cnt < halfLen + quarterLen)       stb.stepDn = 1'b1;
      else                                       stb.stepUp = 1'b1;
    end
  end

  // R8: latched settings move only at the wrap point
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !isLast |=> $stable({cfgMode, cfgCode, cfgRate, cfgActive}));

  // R5: latched depth stays inside the saturation window
  p_code_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    (cfgCode >= MAG_W'(MAG_MIN)) && (cfgCode <= MAG_W'(MAG_MAX)));

  // R4: latched rate never exceeds the slowest code, strobe lasts one cycle
  p_rate_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    cfgRate <= RATE_W'(RATE_MAX));

  p_wrap_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    wrapStb |=> !wrapStb);

  p_stb_onehot_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(stb));

endmodule

// File: rtl/ssmod_dp.sv
module ssmod_dp
  import ssmod_pkg::*;
#(
  parameter int ACC_W     = 24,
  parameter int OFF_W     = 16,
  parameter int MAG_W     = 5,
  parameter int RATE_W    = 2,
  parameter int HALF_LOG2 = 4,
  parameter int UNIT      = 8,
  parameter int MAG_MAX   = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  spreadMode_e       cfgMode,
  input  logic [MAG_W-1:0]  cfgCode,
  input  logic [RATE_W-1:0] cfgRate,
  input  ctrlStb_t          stb,
  output logic [OFF_W-1:0]  offset
);

  localparam int FRAC_W   = ACC_W - OFF_W;
  localparam int MAX_STEP = (MAG_MAX * 2 * UNIT * (2 ** FRAC_W)) >> HALF_LOG2;

  logic signed [ACC_W-1:0] spanAcc;
  logic signed [ACC_W-1:0] halfAcc;
  logic signed [ACC_W-1:0] stepAcc;
  logic signed [ACC_W-1:0] loEnd;
  logic signed [ACC_W-1:0] acc;

  always_comb begin
    spanAcc = $signed(ACC_W'(ACC_W'(cfgCode) * ACC_W'(2 * UNIT)) << FRAC_W);
    halfAcc = spanAcc >>> 1;
    stepAcc = spanAcc >>> (HALF_LOG2 + int'(cfgRate));
    loEnd   = (cfgMode == MODE_CENTER) ? -halfAcc : -spanAcc;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc <= '0;
    end else begin
      if (stb.clear)       acc <= '0;
      else if (stb.snapHi) acc <= halfAcc;
      else if (stb.snapLo) acc <= loEnd;
      else if (stb.stepUp) acc <= acc + stepAcc;
      else if (stb.stepDn) acc <= acc - stepAcc;
    end
  end

  assign offset = acc[ACC_W-1 -: OFF_W];

  // R2: a down sweep never goes above nominal
  p_down_nonpos_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == MODE_DOWN) |-> (acc <= 0));

  // R3: a center sweep stays within half the span either way
  p_center_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfgMode == MODE_CENTER) |-> ((acc <= halfAcc) && (acc >= -halfAcc)));

  // R10: no jump larger than one maximum step
  p_no_jump_r10: assert property (@(posedge clk) disable iff (!rstN)
    ((int'(acc) - int'($past(acc))) <= MAX_STEP) &&
    ((int'(acc) - int'($past(acc))) >= -MAX_STEP));

endmodule

// File: rtl/ss_profile_gen.sv
module ss_profile_gen
  import ssmod_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int ACC_W     = 24,
  parameter int OFF_W     = 16,
  parameter int MAG_W     = 5,
  parameter int RATE_W    = 2,
  parameter int MAG_MIN   = 1,
  parameter int MAG_MAX   = 20,
  parameter int RATE_MAX  = 2,
  parameter int HALF_LOG2 = 4,
  parameter int UNIT      = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        spreadOn,
  input  logic [NCH-1:0]              chanEn,
  input  logic [NCH-1:0]              chanMode,
  input  logic [NCH-1:0][MAG_W-1:0]   chanMag,
  input  logic [NCH-1:0][RATE_W-1:0]  chanRate,
  output logic [NCH-1:0][OFF_W-1:0]   offsetOut,
  output logic [NCH-1:0]              wrapStb
);

  for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
    spreadMode_e       cfgMode;
    logic [MAG_W-1:0]  cfgCode;
    logic [RATE_W-1:0] cfgRate;
    ctrlStb_t          stb;
    logic              gatedEn;

    assign gatedEn = chanEn[ch] & spreadOn;

    ssmod_ctrl #(
      .MAG_W(MAG_W), .RATE_W(RATE_W), .MAG_MIN(MAG_MIN), .MAG_MAX(MAG_MAX),
      .RATE_MAX(RATE_MAX), .HALF_LOG2(HALF_LOG2)
    ) i_ctrl (
      .clk(clk), .rstN(rstN),
      .modeIn(spreadMode_e'(chanMode[ch])), .magIn(chanMag[ch]),
      .rateIn(chanRate[ch]), .enIn(gatedEn),
      .cfgMode(cfgMode), .cfgCode(cfgCode), .cfgRate(cfgRate),
      .stb(stb), .wrapStb(wrapStb[ch])
    );

    ssmod_dp #(
      .ACC_W(ACC_W), .OFF_W(OFF_W), .MAG_W(MAG_W), .RATE_W(RATE_W),
      .HALF_LOG2(HALF_LOG2), .UNIT(UNIT), .MAG_MAX(MAG_MAX)
    ) i_dp (
      .clk(clk), .rstN(rstN),
      .cfgMode(cfgMode), .cfgCode(cfgCode), .cfgRate(cfgRate),
      .stb(stb), .offset(offsetOut[ch])
    );

    // R2: the wrap point is the zero crossing of every sweep
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
      wrapStb[ch] |-> (offsetOut[ch] == '0));
  end

endmodule

// File: tb/test_ss_profile_gen.sv
`timescale 1ns/1ps
module test_ss_profile_gen;

  localparam int HALF_BASE = 16;   // 2**HALF_LOG2
  localparam int UNIT      = 8;
  localparam int FRAC_W    = 8;
  localparam int NVEC      = 8;
  // center, mag, rate, requirement number
  localparam int VEC [NVEC][4] = '{
    '{0,  4, 0, 2},   // R2 down, small depth, fast
    '{1,  4, 0, 3},   // R3 center, same depth
    '{0, 20, 1, 2},   // R2 down, full depth, middle rate
    '{1,  8, 2, 3},   // R3 center, slowest rate
    '{1,  0, 2, 5},   // R5 code 0 acts as 1
    '{0, 31, 0, 5},   // R5 code 31 acts as 20
    '{1,  9, 3, 4},   // R4 rate 3 acts as 2
    '{0,  1, 1, 2}    // R2 minimum depth
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             spreadOn = 1'b1;
  logic [1:0]       chanEn = 2'b00;
  logic [1:0]       chanMode = 2'b00;
  logic [1:0][4:0]  chanMag = '0;
  logic [1:0][1:0]  chanRate = '0;
  logic [1:0][15:0] offsetOut;
  logic [1:0]       wrapStb;

  int testCnt = 0;
  int failCnt = 0;
  int cycles  = 0;

  always #2 clk = ~clk;

  ss_profile_gen i_ss_profile_gen (
    .clk(clk), .rstN(rstN), .spreadOn(spreadOn), .chanEn(chanEn),
    .chanMode(chanMode), .chanMag(chanMag), .chanRate(chanRate),
    .offsetOut(offsetOut), .wrapStb(wrapStb)
  );

  function automatic int model(int center, int mag, int rate, int act, int k);
    int c, r, h, q, s, v;
    if (act == 0) return 0;
    c = (mag < 1) ? 1 : ((mag > 20) ? 20 : mag);
    r = (rate > 2) ? 2 : rate;
    h = HALF_BASE << r;
    q = h / 2;
    s = (c * 2 * UNIT * (1 << FRAC_W)) / h;
    if (center == 0) v = (k <= h) ? -k * s : -(2 * h - k) * s;
    else if (k <= q) v = k * s;
    else if (k <= h + q) v = (h - k) * s;
    else v = (k - 2 * h) * s;
    return v >>> FRAC_W;
  endfunction

  task automatic chk(input bit ok, input string tag, input int got, input int expv);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, got, expv);
    end
  endtask

  // waits for the channel's next wrap and compares one whole sweep
  task automatic checkPeriod(input int ch, input int center, input int mag,
                             input int rate, input int act, input string tag);
    int waitN, bad, r, h, gotV, expV;
    waitN = 0;
    bad = 0;
    r = (rate > 2) ? 2 : rate;
    h = HALF_BASE << r;
    do begin
      @(negedge clk);
      waitN++;
    end while (!wrapStb[ch] && waitN < 400);
    for (int k = 0; k < 2 * h; k++) begin
      if (k > 0) @(negedge clk);
      gotV = int'($signed(offsetOut[ch]));
      expV = model(center, mag, rate, act, k);
      if (bad == 0 && (gotV != expV || wrapStb[ch] != (k == 0))) begin
        bad = 1;
        $display("FAIL %s ch%0d k=%0d actual offset=%0d wrap=%0b expected offset=%0d wrap=%0b",
                 tag, ch, k, gotV, wrapStb[ch], expV, (k == 0));
      end
    end
    testCnt++;
    if (bad != 0) failCnt++;
  endtask

  task automatic setChan(input int ch, input int center, input int mag, input int rate, input bit en);
    chanMode[ch] = center[0];
    chanMag[ch]  = mag[4:0];
    chanRate[ch] = rate[1:0];
    chanEn[ch]   = en;
  endtask

  task automatic waitWrap(input int ch);
    do @(negedge clk); while (!wrapStb[ch]);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failCnt++;
        $display("FAIL watchdog expired after %0d cycles", cycles);
        $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
        $finish;
      end
    end
  end

  initial begin
    int gapN;
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(offsetOut == '0, "R1 offsets in reset", int'(offsetOut[0]), 0);
    chk(wrapStb == 2'b00, "R1 wrap low in reset", int'(wrapStb), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(wrapStb == 2'b11, "R1 wrap after release", int'(wrapStb), 3);

    // table walk on channel 0, channel 1 left disabled
    for (int i = 0; i < NVEC; i++) begin
      setChan(0, VEC[i][0], VEC[i][1], VEC[i][2], 1'b1);
      checkPeriod(0, VEC[i][0], VEC[i][1], VEC[i][2], 1, $sformatf("R%0d vec%0d", VEC[i][3], i));
    end
    // R6: channel 1 never enabled, so its sweep is flat
    checkPeriod(1, 0, 1, 0, 0, "R6 disabled channel flat");

    // R4: wrap spacing at rate 1 is 64 cycles
    setChan(0, 0, 5, 1, 1'b1);
    waitWrap(0);
    waitWrap(0);
    gapN = 0;
    do begin @(negedge clk); gapN++; end while (!wrapStb[0] && gapN < 400);
    chk(gapN == 64, "R4 sweep length rate 1", gapN, 64);

    // R8: mid-sweep setting change ignored until the wrap
    setChan(0, 1, 6, 1, 1'b1);
    fork
      checkPeriod(0, 1, 6, 1, 1, "R8 sweep keeps old settings");
      begin
        waitWrap(0);
        repeat (10) @(negedge clk);
        setChan(0, 0, 15, 0, 1'b1);
      end
    join
    checkPeriod(0, 0, 15, 0, 1, "R8 new settings after wrap");

    // R7: enable dropped mid-sweep, sweep completes then stays at zero
    setChan(0, 0, 10, 0, 1'b1);
    fork
      checkPeriod(0, 0, 10, 0, 1, "R7 sweep completes");
      begin
        waitWrap(0);
        repeat (7) @(negedge clk);
        chanEn[0] = 1'b0;
      end
    join
    checkPeriod(0, 0, 10, 0, 0, "R7 flat after wrap");

    // R6: global input low overrides both channel enables
    spreadOn = 1'b0;
    setChan(0, 1, 12, 0, 1'b1);
    setChan(1, 0, 7, 1, 1'b1);
    fork
      checkPeriod(0, 1, 12, 0, 0, "R6 global off ch0");
      checkPeriod(1, 0, 7, 1, 0, "R6 global off ch1");
    join

    // R9: both channels sweeping with different settings
    spreadOn = 1'b1;
    fork
      checkPeriod(0, 1, 12, 0, 1, "R9 ch0 center rate0");
      checkPeriod(1, 0, 7, 1, 1, "R9 ch1 down rate1");
    join
    setChan(0, 0, 3, 2, 1'b1);
    setChan(1, 1, 18, 0, 1'b1);
    fork
      checkPeriod(0, 0, 3, 2, 1, "R9 ch0 down rate2");
      checkPeriod(1, 1, 18, 0, 1, "R9 ch1 center rate0");
    join

    // R10: full depth at the fastest rate, the steepest slope
    setChan(0, 1, 20, 0, 1'b1);
    checkPeriod(0, 1, 20, 0, 1, "R10 steepest center sweep");

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule